// File: doc/BRIEF.md
# Page Write Collector With In-Page Wrap

This block sits between a serial-memory command decoder and the storage array. A transaction opens with a start strobe that carries a full byte address. Each data byte that follows is parked in a page-sized holding buffer at the current in-page offset. The offset then advances and wraps inside the page, so the page number never changes. Nothing reaches the array while bytes are still arriving. When the stop strobe comes, the block runs a timed commit. It writes every offset that received a byte, and only those, so a partial page leaves its other bytes untouched. Busy is held high for the whole commit time.

During the commit the block ignores every input. An abort strobe discards the buffer. So does a fresh start that arrives before the stop. In both cases nothing is written. The address counter is visible at the ports. After a commit it holds the offset that follows the last byte received, still inside the same page, so a following current-address access can continue from there.

Top module: `pwb_top`

## Requirements
- R1: After reset, busy and mem_we are low and ptr_addr is zero.
- R2: A start strobe loads ptr_addr with the given address. Each accepted byte increments only the low log2(PAGE_BYTES) bits (5 bits for a 32-byte page), wrapping from the last offset to offset 0. The page bits stay unchanged.
- R3: When more than PAGE_BYTES bytes arrive in one transaction, a later byte replaces the buffered byte at the same offset. Only the newest value is committed.
- R4: mem_we stays low until a stop arrives. A stop that follows at least one byte raises busy on the next cycle, and busy stays high for exactly WRITE_CYCLES cycles.
- R5: The commit uses the first PAGE_BYTES cycles of busy, one offset per cycle in ascending order. mem_we is high only on offsets that received a byte. mem_addr is the page bits followed by the offset, and mem_wdata is that offset's buffered byte.
- R6: An abort strobe while collecting, or a new start while collecting, discards all buffered bytes without any write.
- R7: A stop with no buffered byte starts no commit, and busy stays low.
- R8: While busy is high, start, byte, stop and abort strobes are ignored. ptr_addr does not change and no later commit results from them.
- R9: After a commit, ptr_addr holds the page of the transaction and the offset one past the last received byte, modulo PAGE_BYTES.
- R10: When strobes coincide, abort outranks start, start outranks stop, and stop outranks a data byte. The lower-ranked strobes in that cycle are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_start | input | 1 | Opens a write transaction |
| wr_start_addr | input | ADDR_W | Byte address loaded on wr_start |
| byte_vld | input | 1 | Data byte present this cycle |
| byte_dat | input | DATA_W | Data byte |
| stop_req | input | 1 | Closes the transaction and triggers the commit |
| abort_req | input | 1 | Discards the transaction |
| mem_we | output | 1 | Array write enable for one byte |
| mem_addr | output | ADDR_W | Array byte address |
| mem_wdata | output | DATA_W | Array write data |
| busy | output | 1 | Commit in progress |
| ptr_addr | output | ADDR_W | Internal address counter |

## Verification
The hardest case to reach is an overrun that wraps back over offsets already filled, combined with a start address near the end of a page. In that case the newest byte must win and the commit order no longer matches the arrival order. The stimulus starts one transaction at offset 30 so that its bytes wrap at once. It sends another run of 35 bytes so that three offsets are overwritten. The scoreboard rebuilds the expected per-offset contents and pushes the writes in ascending offset order, independently of arrival order. A further run sends strobes in the middle of a commit, and later ones drive several strobes in the same cycle.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

    typedef enum logic [1:0] {
        PW_IDLE   = 2'd0,
        PW_FILL   = 2'd1,
        PW_COMMIT = 2'd2
    } pw_state_e;

    typedef struct packed {
        logic abort;
        logic start;
        logic stop;
        logic push;
    } pw_cmd_t;

    // resolve coincident strobes: abort, then start, then stop, then data
    function automatic pw_cmd_t pw_pick(input logic ab, input logic st,
                                        input logic sp, input logic pu);
        pw_cmd_t c;
        c.abort = ab;
        c.start = !ab && st;
        c.stop  = !ab && !st && sp;
        c.push  = !ab && !st && !sp && pu;
        return c;
    endfunction

endpackage

// File: rtl/pwb_addr_ctr.sv
module pwb_addr_ctr #(
    parameter int ADDR_W = 13,
    parameter int OFF_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              bump,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (load) begin
            addr_q <= load_addr;
        end else if (bump) begin
            // only the in-page bits move; the page bits are held
            addr_q[OFF_W-1:0] <= addr_q[OFF_W-1:0] + OFF_W'(1);
        end
    end

    assign addr = addr_q;
endmodule

// File: rtl/pwb_page_store.sv
module pwb_page_store #(
    parameter int PAGE_BYTES = 32,
    parameter int DATA_W     = 8,
    parameter int OFF_W      = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [OFF_W-1:0]  rd_off,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_vld,
    output logic              any_vld
);
    logic [PAGE_BYTES-1:0] vld_q;
    logic [DATA_W-1:0]     data_q [PAGE_BYTES];

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        logic hit;
        assign hit = wr_en && (wr_off == OFF_W'(g));

        always_ff @(posedge clk) begin
            if (rst || clear) begin
                vld_q[g] <= 1'b0;
            end else if (hit) begin
                vld_q[g] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                data_q[g] <= '0;
            end else if (hit) begin
                data_q[g] <= wr_data;
            end
        end
    end

    assign rd_data = data_q[rd_off];
    assign rd_vld  = vld_q[rd_off];
    assign any_vld = |vld_q;
endmodule

// File: rtl/pwb_commit_seq.sv
module pwb_commit_seq #(
    parameter int PAGE_BYTES   = 32,
    parameter int OFF_W        = 5,
    parameter int WRITE_CYCLES = 200
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    output logic             busy,
    output logic             scan_on,
    output logic [OFF_W-1:0] scan_off,
    output logic             done
);
    localparam int TMR_W = $clog2(WRITE_CYCLES + 1);
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(WRITE_CYCLES - 1);

    logic             busy_q;
    logic [TMR_W-1:0] tmr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            tmr_q  <= '0;
        end else if (busy_q) begin
            if (tmr_q == TMR_LAST) begin
                busy_q <= 1'b0;
                tmr_q  <= '0;
            end else begin
                tmr_q <= tmr_q + TMR_W'(1);
            end
        end else if (go) begin
            busy_q <= 1'b1;
            tmr_q  <= '0;
        end
    end

    assign busy     = busy_q;
    assign done     = busy_q && (tmr_q == TMR_LAST);
    assign scan_on  = busy_q && (32'(tmr_q) < PAGE_BYTES);
    assign scan_off = tmr_q[OFF_W-1:0];
endmodule

// File: rtl/pwb_top.sv
module pwb_top
    import pwb_pkg::*;
#(
    parameter int ADDR_W       = 13,
    parameter int DATA_W       = 8,
    parameter int PAGE_BYTES   = 32,
    parameter int WRITE_CYCLES = 200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_start,
    input  logic [ADDR_W-1:0] wr_start_addr,
    input  logic              byte_vld,
    input  logic [DATA_W-1:0] byte_dat,
    input  logic              stop_req,
    input  logic              abort_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              busy,
    output logic [ADDR_W-1:0] ptr_addr
);
    localparam int OFF_W = $clog2(PAGE_BYTES);

    pw_state_e state_q, state_d;
    pw_cmd_t   cmd;

    logic             filling, start_ok, push_ok, commit_go, commit_done;
    logic             buf_clear, any_vld, rd_vld, scan_on;
    logic [OFF_W-1:0] scan_off;
    logic [DATA_W-1:0] rd_data;

    assign cmd      = pw_pick(abort_req, wr_start, stop_req, byte_vld);
    assign filling  = (state_q == PW_FILL);
    assign start_ok = cmd.start && (state_q != PW_COMMIT);
    assign push_ok  = filling && cmd.push;
    assign commit_go = filling && cmd.stop && any_vld;
    assign buf_clear = start_ok || (filling && (cmd.abort || cmd.stop && !any_vld))
                       || commit_done;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PW_IDLE:   if (cmd.start) state_d = PW_FILL;
            PW_FILL: begin
                if (cmd.abort)      state_d = PW_IDLE;
                else if (cmd.start) state_d = PW_FILL;
                else if (cmd.stop)  state_d = any_vld ? PW_COMMIT : PW_IDLE;
            end
            PW_COMMIT: if (commit_done) state_d = PW_IDLE;
            default:   state_d = PW_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= PW_IDLE;
        else     state_q <= state_d;
    end

    pwb_addr_ctr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_ctr (
        .clk       (clk),
        .rst       (rst),
        .load      (start_ok),
        .load_addr (wr_start_addr),
        .bump      (push_ok),
        .addr      (ptr_addr)
    );

    pwb_page_store #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W), .OFF_W(OFF_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .clear   (buf_clear),
        .wr_en   (push_ok),
        .wr_off  (ptr_addr[OFF_W-1:0]),
        .wr_data (byte_dat),
        .rd_off  (scan_off),
        .rd_data (rd_data),
        .rd_vld  (rd_vld),
        .any_vld (any_vld)
    );

    pwb_commit_seq #(.PAGE_BYTES(PAGE_BYTES), .OFF_W(OFF_W),
                     .WRITE_CYCLES(WRITE_CYCLES)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .go       (commit_go),
        .busy     (busy),
        .scan_on  (scan_on),
        .scan_off (scan_off),
        .done     (commit_done)
    );

    assign mem_we    = scan_on && rd_vld;
    assign mem_addr  = {ptr_addr[ADDR_W-1:OFF_W], scan_off};
    assign mem_wdata = rd_data;
endmodule

// File: rtl/pwb_chk.sv
module pwb_chk #(
    parameter int ADDR_W       = 13,
    parameter int PAGE_BYTES   = 32,
    parameter int WRITE_CYCLES = 200
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_start,
    input logic              stop_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              busy,
    input logic [ADDR_W-1:0] ptr_addr
);
    localparam int OFF_W = $clog2(PAGE_BYTES);

    int run_q;
    always_ff @(posedge clk) begin
        if (rst)       run_q <= 0;
        else if (busy) run_q <= run_q + 1;
        else           run_q <= 0;
    end

    // R4
    we_needs_busy_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> busy);

    // R4
    busy_after_stop_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(stop_req));

    // R4
    busy_bound_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> run_q < WRITE_CYCLES);

    // R4
    busy_exact_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(run_q) == WRITE_CYCLES - 1);

    // R5
    write_page_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_addr[ADDR_W-1:OFF_W] == ptr_addr[ADDR_W-1:OFF_W]);

    // R2
    page_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_start) |-> ptr_addr[ADDR_W-1:OFF_W] == $past(ptr_addr[ADDR_W-1:OFF_W]));

    // R8
    ptr_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(ptr_addr));
endmodule

bind pwb_top pwb_chk #(
    .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .WRITE_CYCLES(WRITE_CYCLES)
) u_chk (
    .clk(clk), .rst(rst), .wr_start(wr_start), .stop_req(stop_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .busy(busy), .ptr_addr(ptr_addr)
);

// File: tb/pwb_top_test.sv
module pwb_top_test;
    localparam int AW = 13;
    localparam int DW = 8;
    localparam int PB = 32;
    localparam int WC = 48;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_start = 0, byte_vld = 0, stop_req = 0, abort_req = 0;
    logic [AW-1:0] wr_start_addr = '0;
    logic [DW-1:0] byte_dat = '0;
    logic mem_we, busy;
    logic [AW-1:0] mem_addr, ptr_addr;
    logic [DW-1:0] mem_wdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    pwb_top #(.ADDR_W(AW), .DATA_W(DW), .PAGE_BYTES(PB), .WRITE_CYCLES(WC)) uut (
        .clk(clk), .rst(rst), .wr_start(wr_start), .wr_start_addr(wr_start_addr),
        .byte_vld(byte_vld), .byte_dat(byte_dat), .stop_req(stop_req),
        .abort_req(abort_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .busy(busy), .ptr_addr(ptr_addr)
    );

    always #4 clk = ~clk;

    // reference model of the requirements
    logic [DW-1:0] m_buf [PB];
    logic [PB-1:0] m_mask = '0;
    int m_page = 0, m_off = 0;
    bit m_fill = 0;
    logic [AW+DW-1:0] expq [$];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int m_ptr();
        return m_page * PB + m_off;
    endfunction

    task automatic raw(input logic a, input logic s, input logic sp, input logic p,
                       input logic [DW-1:0] d, input logic [AW-1:0] ad);
        @(posedge clk);
        #1;
        abort_req = a; wr_start = s; stop_req = sp; byte_vld = p;
        byte_dat = d; wr_start_addr = ad;
    endtask

    task automatic drv(input logic a, input logic s, input logic sp, input logic p,
                       input logic [DW-1:0] d, input logic [AW-1:0] ad);
        raw(a, s, sp, p, d, ad);
        if (a) begin
            if (m_fill) begin m_fill = 0; m_mask = '0; end
        end else if (s) begin
            m_fill = 1; m_mask = '0;
            m_page = int'(ad) / PB; m_off = int'(ad) % PB;
        end else if (sp) begin
            if (m_fill) begin
                for (int o = 0; o < PB; o++)
                    if (m_mask[o]) expq.push_back({AW'(m_page * PB + o), m_buf[o]});
                m_fill = 0; m_mask = '0;
            end
        end else if (p && m_fill) begin
            m_buf[m_off] = d; m_mask[m_off] = 1'b1; m_off = (m_off + 1) % PB;
        end
    endtask

    task automatic idle();
        raw(0, 0, 0, 0, '0, '0);
    endtask

    // monitor: compare each array write against the scoreboard
    always @(negedge clk) begin
        if (!rst && mem_we) begin
            if (expq.size() == 0) begin
                check(0, "R5/R6/R8 unexpected write", int'(mem_addr), 0);
            end else begin
                logic [AW+DW-1:0] e;
                e = expq.pop_front();
                check(mem_addr == e[AW+DW-1:DW], "R5 write address", int'(mem_addr),
                      int'(e[AW+DW-1:DW]));
                check(mem_wdata == e[DW-1:0], "R3/R5 write data", int'(mem_wdata),
                      int'(e[DW-1:0]));
            end
        end
    end

    // count busy cycles after a stop; caller sits one step past the stop
    task automatic wait_commit(input string tag, input int exp_len);
        int n = 0;
        @(negedge clk);
        while (busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
        check(n == exp_len, tag, n, exp_len);
        check(expq.size() == 0, "R5 all expected writes seen", expq.size(), 0);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            check(0, "watchdog", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        // R1
        check(busy == 0 && mem_we == 0, "R1 reset outputs", {busy, mem_we}, 0);
        check(ptr_addr == 0, "R1 reset pointer", int'(ptr_addr), 0);

        // single byte, R2 R4 R9
        drv(0, 1, 0, 0, '0, 13'h0123);
        drv(0, 0, 0, 1, 8'hA5, '0);
        idle();
        @(negedge clk);
        check(ptr_addr == 13'h0124, "R2 increment", int'(ptr_addr), 'h124);
        check(mem_we == 0 && busy == 0, "R4 no write before stop", {busy, mem_we}, 0);
        drv(0, 0, 1, 0, '0, '0);
        idle();
        wait_commit("R4 busy length single", WC);
        check(ptr_addr == AW'(m_ptr()), "R9 pointer after single", int'(ptr_addr), m_ptr());

        // start at offset 30, 5 bytes wrap: R2 R5 R9
        drv(0, 1, 0, 0, '0, 13'h0A5E);
        for (int i = 0; i < 5; i++) drv(0, 0, 0, 1, DW'(8'h10 + i), '0);
        idle();
        @(negedge clk);
        check(ptr_addr == 13'h0A43, "R2 wrap inside page", int'(ptr_addr), 'hA43);
        drv(0, 0, 1, 0, '0, '0);
        idle();
        wait_commit("R4 busy length wrap", WC);

        // 35 bytes overrun: R3 R9
        drv(0, 1, 0, 0, '0, 13'h1F00);
        for (int i = 0; i < 35; i++) drv(0, 0, 0, 1, DW'(i * 7 + 1), '0);
        drv(0, 0, 1, 0, '0, '0);
        idle();
        wait_commit("R3 busy length overrun", WC);
        check(ptr_addr == 13'h1F03, "R9 pointer after overrun", int'(ptr_addr), 'h1F03);

        // last address of the array: R2 R9
        drv(0, 1, 0, 0, '0, 13'h1FFF);
        drv(0, 0, 0, 1, 8'h3C, '0);
        drv(0, 0, 1, 0, '0, '0);
        idle();
        wait_commit("R4 busy length top", WC);
        check(ptr_addr == 13'h1FE0, "R9 pointer wraps to page start", int'(ptr_addr), 'h1FE0);

        // abort discards: R6
        drv(0, 1, 0, 0, '0, 13'h0200);
        drv(0, 0, 0, 1, 8'h11, '0);
        drv(1, 0, 0, 0, '0, '0);
        drv(0, 0, 1, 0, '0, '0);
        idle();
        repeat (3) @(negedge clk);
        check(busy == 0, "R6 abort leaves no commit", busy, 0);

        // restart discards: R6
        drv(0, 1, 0, 0, '0, 13'h0300);
        drv(0, 0, 0, 1, 8'h22, '0);
        drv(0, 1, 0, 0, '0, 13'h0340);
        drv(0, 0, 0, 1, 8'h33, '0);
        drv(0, 0, 1, 0, '0, '0);
        idle();
        wait_commit("R6 restart commits only new bytes", WC);

        // empty stop: R7
        drv(0, 1, 0, 0, '0, 13'h0400);
        drv(0, 0, 1, 0, '0, '0);
        idle();
        repeat (3) @(negedge clk);
        check(busy == 0, "R7 empty stop", busy, 0);

        // inputs during busy: R8
        drv(0, 1, 0, 0, '0, 13'h0500);
        drv(0, 0, 0, 1, 8'h44, '0);
        drv(0, 0, 1, 0, '0, '0);
        repeat (PB + 3) idle();
        raw(0, 1, 0, 0, '0, 13'h0777);
        raw(0, 0, 0, 1, 8'h99, '0);
        raw(0, 0, 1, 0, '0, '0);
        raw(1, 0, 0, 0, '0, '0);
        idle();
        @(negedge clk);
        check(ptr_addr == 13'h0501, "R8 pointer frozen while busy", int'(ptr_addr), 'h501);
        while (busy) @(negedge clk);
        repeat (4) idle();
        @(negedge clk);
        check(busy == 0, "R8 no commit from ignored strobes", busy, 0);
        check(ptr_addr == 13'h0501, "R8 pointer after busy", int'(ptr_addr), 'h501);

        // priority: R10
        drv(0, 1, 0, 0, '0, 13'h0600);
        drv(0, 1, 0, 1, 8'h55, 13'h0610);
        idle();
        @(negedge clk);
        check(ptr_addr == 13'h0610, "R10 start beats byte", int'(ptr_addr), 'h610);
        drv(0, 0, 0, 1, 8'h66, '0);
        drv(1, 1, 1, 1, 8'h77, 13'h0700);
        idle();
        @(negedge clk);
        check(busy == 0 && ptr_addr == 13'h0611, "R10 abort beats all",
              int'(ptr_addr), 'h611);
        drv(0, 1, 0, 0, '0, 13'h0800);
        drv(0, 0, 0, 1, 8'h88, '0);
        drv(0, 0, 1, 1, 8'h99, '0);
        idle();
        wait_commit("R10 stop beats byte", WC);
        check(ptr_addr == 13'h0801, "R10 byte dropped with stop", int'(ptr_addr), 'h801);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule